// File: doc/BRIEF.md
# Phase-Keyed Direct Digital Carrier Generator

This block synthesizes a sampled sine carrier from a reference clock and keys its phase between two states with a single data bit. On every clock, an N-bit phase register advances by a programmable step. The carrier frequency is therefore step × f_clk / 2^N. With the default width of 20 bits and a 125 MHz clock, one step unit corresponds to roughly 119 Hz.

Before lookup, the running phase is summed with a keying offset. The offset is zero while the data bit is low and half a turn while it is high, so a data change reverses the carrier's polarity. The top ten bits of that sum address a quarter-wave table that is built during elaboration. Mirror and sign logic around the table turn each address into a 12-bit signed sample.

The step word and the data bit are held in internal registers. Each one changes only when its own load strobe is high, so the carrier frequency can be reprogrammed at run time with no other reconfiguration. Driving the data load strobe on a fixed schedule produces periodic phase reversals for binary phase-shift keying.

Top module: `dds_bpsk_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the sample output is 0. Reset clears the phase, the stored step and the stored data bit.
- R2: The phase register advances by the stored step on every clock, modulo 2^N. The sample equals round(2047 × sin(2π·a/1024)), where a is bits [N-1:N-10] of the phase plus the keying offset, taken modulo 2^N.
- R3: `freqWord` is captured on a clock edge where `freqLoad` is 1. The new step is first added on the following edge. While `freqLoad` is 0, changes on `freqWord` have no effect.
- R4: `dataBit` is captured on a clock edge where `dataLoad` is 1. A stored 1 adds an offset of 2^(N-1), and a stored 0 adds nothing. While `dataLoad` is 0, changes on `dataBit` have no effect.
- R5: A phase value reaches the output two clock edges after it is formed. After a data load edge, the output shows the new polarity on the second following edge.
- R6: With the phase frozen, changing the stored data bit turns the sample into its exact negative.
- R7: With a stored step of 0 and data 0 after reset, the output stays at sin(0) = 0, and the phase register does not move.
- R8: A step with its top bit set wraps the phase modulo 2^N. This acts as a negative frequency, and the sample sequence still follows R2.
- R9: At N = 32, the block follows R2 with no other change. For example, a step of 764504178 gives a carrier near 0.178 × f_clk, about 22.2 MHz at 125 MHz.
- R10: A data bit that is reloaded with alternating values every fixed number of clocks gives periodic polarity reversals that follow R2 and R4.
- R11: The sample never takes the value −2048. Its sign bit is set only for table addresses in the upper half-turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freqWord | input | ACC_W | Phase step (frequency control word) |
| freqLoad | input | 1 | Captures `freqWord` on this edge |
| dataBit | input | 1 | Keying bit: 0 = no offset, 1 = half-turn offset |
| dataLoad | input | 1 | Captures `dataBit` on this edge |
| sineOut | output | SAMPLE_W | Signed two's-complement carrier sample |

## Verification
Some properties are checked on every cycle by the assertions:
- A stored step or data bit changes only after its load strobe.
- The accumulator is frozen while the stored step is zero.
- The output's sign follows the quadrant latched one stage earlier.
- The output never reaches the most negative code.

The bench's directed scenarios are needed for the rest. They compare every sample against an independent sine model, across:
- step loads, including ignored word changes;
- a reversed-direction wrap;
- periodic keying;
- the 32-bit width.

They also measure the exact two-edge latency and the exact negation on a polarity flip, and they check the sample period against the step.

// File: rtl/dds_bpsk_pkg.sv
package dds_bpsk_pkg;

  // Default geometry of the lookup and the sample
  localparam int DEF_ADDR_W   = 10;
  localparam int DEF_SAMPLE_W = 12;

  // Strobes from control to datapath
  typedef struct packed {
    logic offsetOn;   // add a half-turn to the phase before lookup
    logic stepZero;   // stored step is zero: accumulator may stay idle
  } dds_ctl_t;

endpackage

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int QTR_W = 8,
  parameter int MAG_W = 11
) (
  input  logic [QTR_W:0]   idx,
  output logic [MAG_W-1:0] mag
);

  localparam int  QTR_SIZE = 1 << QTR_W;
  localparam int  FULL_MAG = (1 << MAG_W) - 1;
  localparam real PI_C     = 3.14159265358979323846;

  logic [MAG_W-1:0] tab [QTR_SIZE];

  // One quarter of a sine, entries 0 .. QTR_SIZE-1, built at elaboration
  for (genvar i = 0; i < QTR_SIZE; i++) begin : g_tab
    localparam real ANG = 2.0 * PI_C * i / (4.0 * QTR_SIZE);
    localparam int  VAL = int'(FULL_MAG * $sin(ANG));
    assign tab[i] = VAL[MAG_W-1:0];
  end

  // The index QTR_SIZE (peak) is the only value with its top bit set
  always_comb begin
    if (idx[QTR_W]) mag = FULL_MAG[MAG_W-1:0];
    else            mag = tab[idx[QTR_W-1:0]];
  end

endmodule

// File: rtl/dds_bpsk_ctrl.sv
module dds_bpsk_ctrl
  import dds_bpsk_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freqWord,
  input  logic             freqLoad,
  input  logic             dataBit,
  input  logic             dataLoad,
  output logic [ACC_W-1:0] stepWord,
  output dds_ctl_t         ctl
);

  logic symReg;
  logic stepZeroReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepWord    <= '0;
      stepZeroReg <= 1'b1;
    end else if (freqLoad) begin
      stepWord    <= freqWord;
      stepZeroReg <= (freqWord == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        symReg <= 1'b0;
    else if (dataLoad) symReg <= dataBit;
  end

  always_comb begin
    ctl.offsetOn = symReg;
    ctl.stepZero = stepZeroReg;
  end

  // Step held unless its strobe was seen (R3)
  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(freqLoad) |-> $stable(stepWord));

  // Keying bit held unless its strobe was seen (R4)
  assert_sym_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dataLoad) |-> $stable(symReg));

endmodule

// File: rtl/dds_phase_path.sv
module dds_phase_path
  import dds_bpsk_pkg::*;
#(
  parameter int ACC_W    = 20,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ACC_W-1:0]           stepWord,
  input  dds_ctl_t                   ctl,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam int QTR_W = ADDR_W - 2;
  localparam int MAG_W = SAMPLE_W - 1;
  localparam logic [ACC_W-1:0] HALF_TURN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [QTR_W:0]   QTR_SIZE  = {1'b1, {QTR_W{1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [ACC_W-1:0]  phaseAcc;
  logic [ACC_W-1:0]  sumPhase;
  logic [ADDR_W-1:0] lutAddr;
  logic [QTR_W-1:0]  lowIdx;
  logic [QTR_W:0]    mirIdx;
  logic [MAG_W-1:0]  romMag;
  logic [MAG_W-1:0]  magQ;
  logic              negQ;

  // Phase accumulator, idle while the stored step is zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phaseAcc <= '0;
    else if (!ctl.stepZero) phaseAcc <= phaseAcc + stepWord;
  end

  // Keying offset, then quadrant split of the table address
  always_comb begin
    sumPhase = phaseAcc + (ctl.offsetOn ? HALF_TURN : '0);
    lutAddr  = sumPhase[ACC_W-1 -: ADDR_W];
    lowIdx   = lutAddr[QTR_W-1:0];
    if (lutAddr[QTR_W]) mirIdx = QTR_SIZE - {1'b0, lowIdx};
    else                mirIdx = {1'b0, lowIdx};
  end

  dds_quarter_rom #(
    .QTR_W(QTR_W),
    .MAG_W(MAG_W)
  ) u_rom (
    .idx(mirIdx),
    .mag(romMag)
  );

  // Stage 1: magnitude and sign
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      magQ <= '0;
      negQ <= 1'b0;
    end else begin
      magQ <= romMag;
      negQ <= lutAddr[ADDR_W-1];
    end
  end

  // Stage 2: signed sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sampleOut <= '0;
    else if (negQ) sampleOut <= -$signed({1'b0, magQ});
    else           sampleOut <= $signed({1'b0, magQ});
  end

  // Idle flag from control agrees with the step it accompanies (R7)
  assert_idle_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepZero |-> (stepWord == '0));

  // Zero step leaves the phase where it was (R7)
  assert_phase_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepZero |=> $stable(phaseAcc));

  // Output sign follows the latched quadrant (R2, R11)
  assert_sign_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(negQ) |-> (sampleOut <= 0));
  assert_pos_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(negQ) |-> (sampleOut >= 0));

  // Most negative code never produced (R11)
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sampleOut != MOST_NEG);

endmodule

// File: rtl/dds_bpsk_gen.sv
module dds_bpsk_gen
  import dds_bpsk_pkg::*;
#(
  parameter int ACC_W    = 20,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ACC_W-1:0]           freqWord,
  input  logic                       freqLoad,
  input  logic                       dataBit,
  input  logic                       dataLoad,
  output logic signed [SAMPLE_W-1:0] sineOut
);

  logic [ACC_W-1:0] stepWord;
  dds_ctl_t         ctl;

  dds_bpsk_ctrl #(
    .ACC_W(ACC_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .freqWord(freqWord),
    .freqLoad(freqLoad),
    .dataBit (dataBit),
    .dataLoad(dataLoad),
    .stepWord(stepWord),
    .ctl     (ctl)
  );

  dds_phase_path #(
    .ACC_W   (ACC_W),
    .ADDR_W  (ADDR_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .stepWord (stepWord),
    .ctl      (ctl),
    .sampleOut(sineOut)
  );

endmodule

// File: tb/sim_dds_bpsk_gen.sv
module sim_ref_carrier #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] freqWord,
  input  logic         freqLoad,
  input  logic         dataBit,
  input  logic         dataLoad,
  output int           expOut
);
  localparam real PI_C = 3.14159265358979323846;

  logic [N-1:0] mK;
  logic [N-1:0] mAcc;
  logic [N-1:0] mSum;
  logic         mD;
  int           s1;

  function automatic int refSample(int a);
    real ang;
    ang = 2.0 * PI_C * a / 1024.0;
    return int'(2047.0 * $sin(ang));
  endfunction

  always_comb mSum = mAcc + (mD ? (N'(1) << (N - 1)) : N'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mK <= '0; mAcc <= '0; mD <= 1'b0; s1 <= 0; expOut <= 0;
    end else begin
      if (freqLoad) mK <= freqWord;
      if (dataLoad) mD <= dataBit;
      mAcc   <= mAcc + mK;
      s1     <= refSample(int'(mSum[N-1 -: 10]));
      expOut <= s1;
    end
  end
endmodule

module sim_dds_bpsk_gen;
  localparam int CLK_PERIOD = 8;
  localparam int N0 = 20;
  localparam int N1 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N0-1:0] freqWord = '0;
  logic freqLoad = 1'b0, dataBit = 1'b0, dataLoad = 1'b0;
  logic signed [11:0] sineOut;
  logic [N1-1:0] wFreq = '0;
  logic wLoad = 1'b0;
  logic signed [11:0] wOut;
  int exp0, exp1;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_bpsk_gen #(.ACC_W(N0)) u0 (
    .clk(clk), .rst_n(rst_n), .freqWord(freqWord), .freqLoad(freqLoad),
    .dataBit(dataBit), .dataLoad(dataLoad), .sineOut(sineOut));

  dds_bpsk_gen #(.ACC_W(N1)) u1 (
    .clk(clk), .rst_n(rst_n), .freqWord(wFreq), .freqLoad(wLoad),
    .dataBit(1'b0), .dataLoad(1'b0), .sineOut(wOut));

  sim_ref_carrier #(.N(N0)) m0 (
    .clk(clk), .rst_n(rst_n), .freqWord(freqWord), .freqLoad(freqLoad),
    .dataBit(dataBit), .dataLoad(dataLoad), .expOut(exp0));

  sim_ref_carrier #(.N(N1)) m1 (
    .clk(clk), .rst_n(rst_n), .freqWord(wFreq), .freqLoad(wLoad),
    .dataBit(1'b0), .dataLoad(1'b0), .expOut(exp1));

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Step to the next negative edge, then compare both instances to the model
  task automatic cmpCycles(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, int'(sineOut), exp0);
      chk("R11", int'(sineOut == -12'sd2048), 0);
    end
  endtask

  task automatic pulseFreq(logic [N0-1:0] k);
    freqWord = k; freqLoad = 1'b1;
    @(negedge clk);
    freqLoad = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    freqLoad = 1'b0; dataLoad = 1'b0; dataBit = 1'b0; wLoad = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 reset", int'(sineOut), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(sineOut), 0);
  endtask

  // R7: idle step, zero data: constant sin(0)
  task automatic tIdle();
    doReset();
    freqWord = 20'h12345;   // not loaded: must be ignored (R3)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R7 idle", int'(sineOut), 0);
      chk("R3 ignored word", int'(sineOut), exp0);
    end
  endtask

  // R2/R3/R5: load a step of 2^(N-4); period 16; compare against model
  task automatic tFreq();
    int hist [64];
    doReset();
    pulseFreq(20'h10000);
    cmpCycles(4, "R5 R3 load");
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      hist[i] = int'(sineOut);
      chk("R2 model", hist[i], exp0);
      if (i >= 16) chk("R2 period", hist[i], hist[i-16]);
    end
    freqWord = 20'h00777;   // change without strobe (R3)
    cmpCycles(16, "R3 ignored word");
    pulseFreq(20'h03a51);   // run-time retune (R3)
    cmpCycles(40, "R3 retune");
  endtask

  // R5/R6: freeze phase, flip data, watch the exact edge and the negation
  task automatic tFlip();
    int v;
    doReset();
    pulseFreq(20'h33039);
    pulseFreq(20'h00000);
    cmpCycles(4, "R7 frozen");
    v = int'(sineOut);
    chk("R6 nonzero start", int'(v != 0), 1);
    dataBit = 1'b1; dataLoad = 1'b1;
    @(negedge clk);
    dataLoad = 1'b0;
    dataBit  = 1'b0;        // not loaded: ignored (R4)
    chk("R5 edge1 old", int'(sineOut), v);
    @(negedge clk);
    chk("R5 edge2 old", int'(sineOut), v);
    @(negedge clk);
    chk("R6 negated", int'(sineOut), -v);
    cmpCycles(6, "R4 held");
    chk("R4 ignored bit", int'(sineOut), -v);
  endtask

  // R10/R4: data reloaded every 8 clocks with alternating values
  task automatic tToggle();
    doReset();
    pulseFreq(20'h02d00);
    for (int p = 0; p < 12; p++) begin
      dataBit = p[0]; dataLoad = 1'b1;
      @(negedge clk);
      chk("R10 toggle", int'(sineOut), exp0);
      dataLoad = 1'b0;
      cmpCycles(7, "R10 toggle");
    end
  endtask

  // R8: step with top bit set runs backward and wraps
  task automatic tWrap();
    doReset();
    pulseFreq(20'hF8000);   // -2^(N-5): period 32, decreasing phase
    cmpCycles(80, "R8 wrap");
    pulseFreq(20'hFFFFF);
    cmpCycles(20, "R8 wrap minus one");
  endtask

  // R9: 32-bit instance, step near 0.178 of the clock
  task automatic tWide();
    int prevSign, nCross;
    doReset();
    wFreq = 32'd764504178; wLoad = 1'b1;
    @(negedge clk);
    wLoad = 1'b0;
    prevSign = 0; nCross = 0;
    for (int i = 0; i < 204; i++) begin
      @(negedge clk);
      chk("R9 wide model", int'(wOut), exp1);
      if (i >= 4 && wOut != 0) begin
        if (prevSign != 0 && ((wOut > 0) != (prevSign > 0))) nCross++;
        prevSign = (wOut > 0) ? 1 : -1;
      end
    end
    chk("R9 crossings in range", int'(nCross >= 66 && nCross <= 76), 1);
  endtask

  initial begin
    tIdle();
    tFreq();
    tFlip();
    tToggle();
    tWrap();
    tWide();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule